// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block sits between a host that wants an SMBus transaction and a bit-level engine that drives SCL and SDA. The host picks a transaction kind, a 7-bit target address, a command byte, two word bytes and, for the block kinds, a byte count, and then pulses `go`. The sequencer breaks the transaction into an ordered series of bus primitives (start, repeated start, write a byte, read a byte and answer ACK, read a byte and answer NACK, stop). It hands the engine one primitive at a time and waits for the engine to finish each one.

Every write primitive returns the target's acknowledge bit, and every read primitive returns the received byte. Bytes that arrive in the data phase are stored in arrival order in a small buffer that the host reads after `done`. A target that fails to acknowledge, or a block count outside 1 to `MAX_BLK`, ends the transaction early with a stop and the error flag. Block-write payload bytes are fetched from the host through an index and data pair.

The controller is one state machine with the states IDLE, START, ADDR_W, CMD, WDAT, RSTART, ADDR_R, RCNT, RDAT, STOP and DONE. IDLE goes to START on `go`, or to DONE with error when the request is invalid. START goes to ADDR_W. ADDR_W goes to STOP on a NACK or a quick command, and to CMD otherwise. CMD goes to WDAT when write bytes follow, to RSTART when only a read follows, and to STOP otherwise. WDAT loops until the last write byte and then goes to RSTART or STOP. RSTART goes to ADDR_R. ADDR_R goes to RCNT for counted reads and to RDAT otherwise. RCNT goes to RDAT, or to STOP with error on a bad count. RDAT loops until the last byte and then goes to STOP. STOP goes to DONE, and DONE returns to IDLE.

Top module: `smb_txn_seq`

## Requirements
- R1: Transaction codes on `txn_type` are 0 quick, 1 read byte, 2 write byte, 3 read word, 4 write word, 5 process call, 6 block read, 7 block write, 8 block process call, 9 raw block read, 10 raw block write. The primitive codes on `prim_op` are 1 start, 2 repeated start, 3 write byte, 4 read with ACK, 5 read with NACK and 6 stop. A quick command issues start, then a write of `{addr, quick_bit}`, then stop.
- R2: Every kind except quick begins with start, then a write of `{addr,0}`, then a write of the command byte. A kind that reads then issues a repeated start, a write of `{addr,1}`, and the read phase. Write byte sends `wr_lo` after the command.
- R3: Words travel low byte first. Write word sends `wr_lo` and then `wr_hi`. Read word reads two bytes, and they land in buffer entries 0 and 1.
- R4: In every read phase each byte except the last uses op 4 (ACK), and the last byte uses op 5 (NACK) before stop.
- R5: Block read and block process call read a count byte with ACK first, and then read that many data bytes. A count of 0 or above `MAX_BLK` causes a stop right after the count byte and sets `error`, and `rx_count` stays 0.
- R6: Block write sends the command, then `wr_count`, then `wr_count` payload bytes. Payload byte i is taken from `blk_wr_byte` while `blk_wr_idx` equals i.
- R7: Process call writes the command, `wr_lo` and `wr_hi`, then does a repeated start and reads two bytes with no stop in between. Block process call writes the count and payload like R6, then performs a counted read like R5.
- R8: Raw block write sends the payload with no count byte. Raw block read reads `wr_count` bytes with no count byte.
- R9: A NACK on any write primitive (address, command, count or data) is followed at once by stop, and `error` is set.
- R10: An unknown `txn_type` (11 to 15), or a block kind that needs `wr_count` while `wr_count` is 0 or above `MAX_BLK`, produces no primitives at all, and `done` and `error` are raised.
- R11: Data-phase bytes are written to buffer entries 0, 1, 2 and so on in arrival order, and the count byte is not stored. `rx_count` gives the number of bytes stored and never exceeds `MAX_BLK`.
- R12: `done` is high for exactly one cycle, in the cycle after the cycle in which the stop primitive completes. `error` is valid with `done` and holds until the next `go`.
- R13: `prim_valid` stays high, with `prim_op` and `prim_byte` stable, until the engine answers with `prim_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start a transaction (one-cycle pulse while idle) |
| txn_type | input | 4 | Transaction kind code |
| dev_addr | input | 7 | Target address |
| quick_bit | input | 1 | Value sent in the R/W position for a quick command |
| cmd_byte | input | 8 | Command byte |
| wr_lo | input | 8 | Byte or word low byte to write |
| wr_hi | input | 8 | Word high byte to write |
| wr_count | input | CW (6) | Block length for block writes and raw reads |
| blk_wr_idx | output | AW (5) | Index of the payload byte being requested |
| blk_wr_byte | input | 8 | Payload byte at `blk_wr_idx` |
| prim_valid | output | 1 | Primitive request to the bit engine |
| prim_op | output | 3 | Primitive code |
| prim_byte | output | 8 | Byte to send for write primitives |
| prim_done | input | 1 | Engine finished the current primitive |
| prim_ack | input | 1 | Acknowledge bit returned by a write (1 = ACK) |
| prim_rx | input | 8 | Byte returned by a read |
| rbuf_idx | input | AW (5) | Read-buffer entry to show |
| rbuf_data | output | 8 | Contents of the selected buffer entry |
| rx_count | output | CW (6) | Number of data bytes stored |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Transaction aborted or rejected |

## Verification
The bench builds the block with its default `MAX_BLK` of 32, so every limit is at its real value. The sweep covers all eleven kinds plus unknown codes. Block lengths of 1, 2, 5 and 32 are applied, together with the rejected values 0 and 33. Returned counts of 1, 4 and 32 are applied, together with 0 and 33. For short kinds the target NACKs in turn on the address, on the command and on the first and last write bytes, so each abort point is reached. The bench models the bit engine with a latency that changes for each primitive. It compares the whole primitive trace, the buffer contents, `rx_count`, `error` and the position of `done` against a trace it builds from the requirements.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [3:0] {
        TX_QUICK    = 4'd0,
        TX_RD_BYTE  = 4'd1,
        TX_WR_BYTE  = 4'd2,
        TX_RD_WORD  = 4'd3,
        TX_WR_WORD  = 4'd4,
        TX_PROC     = 4'd5,
        TX_BLK_RD   = 4'd6,
        TX_BLK_WR   = 4'd7,
        TX_BLK_PROC = 4'd8,
        TX_RAW_RD   = 4'd9,
        TX_RAW_WR   = 4'd10
    } txn_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RSTART  = 3'd2,
        OP_WRITE   = 3'd3,
        OP_RD_ACK  = 3'd4,
        OP_RD_NACK = 3'd5,
        OP_STOP    = 3'd6
    } prim_e;

    typedef enum logic [2:0] {
        WM_NONE, WM_BYTE, WM_WORD, WM_BLK_CNT, WM_BLK_RAW
    } wmode_e;

    typedef enum logic [2:0] {
        RM_NONE, RM_BYTE, RM_WORD, RM_CNT, RM_RAW
    } rmode_e;

    typedef struct packed {
        logic   quick;
        logic   bad;
        logic   needs_len;
        wmode_e wm;
        rmode_e rm;
    } plan_t;

endpackage

// File: rtl/smb_txn_decode.sv
module smb_txn_decode
    import smb_seq_pkg::*;
(
    input  logic [3:0] kind,
    output plan_t      plan
);
    always_comb begin
        plan = '{quick: 1'b0, bad: 1'b0, needs_len: 1'b0, wm: WM_NONE, rm: RM_NONE};
        unique case (kind)
            TX_QUICK:    plan.quick = 1'b1;
            TX_RD_BYTE:  plan.rm = RM_BYTE;
            TX_WR_BYTE:  plan.wm = WM_BYTE;
            TX_RD_WORD:  plan.rm = RM_WORD;
            TX_WR_WORD:  plan.wm = WM_WORD;
            TX_PROC:     begin plan.wm = WM_WORD;    plan.rm = RM_WORD; end
            TX_BLK_RD:   plan.rm = RM_CNT;
            TX_BLK_WR:   begin plan.wm = WM_BLK_CNT; plan.needs_len = 1'b1; end
            TX_BLK_PROC: begin plan.wm = WM_BLK_CNT; plan.rm = RM_CNT; plan.needs_len = 1'b1; end
            TX_RAW_RD:   begin plan.rm = RM_RAW;     plan.needs_len = 1'b1; end
            TX_RAW_WR:   begin plan.wm = WM_BLK_RAW; plan.needs_len = 1'b1; end
            default:     plan.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/smb_rx_buf.sv
module smb_rx_buf #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ridx,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
    import smb_seq_pkg::*;
#(
    parameter int MAX_BLK = 32,
    localparam int CW = $clog2(MAX_BLK + 2),
    localparam int AW = $clog2(MAX_BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [3:0]    txn_type,
    input  logic [6:0]    dev_addr,
    input  logic          quick_bit,
    input  logic [7:0]    cmd_byte,
    input  logic [7:0]    wr_lo,
    input  logic [7:0]    wr_hi,
    input  logic [CW-1:0] wr_count,
    output logic [AW-1:0] blk_wr_idx,
    input  logic [7:0]    blk_wr_byte,
    output logic          prim_valid,
    output logic [2:0]    prim_op,
    output logic [7:0]    prim_byte,
    input  logic          prim_done,
    input  logic          prim_ack,
    input  logic [7:0]    prim_rx,
    input  logic [AW-1:0] rbuf_idx,
    output logic [7:0]    rbuf_data,
    output logic [CW-1:0] rx_count,
    output logic          done,
    output logic          error
);
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR_W, S_CMD, S_WDAT, S_RSTART,
        S_ADDR_R, S_RCNT, S_RDAT, S_STOP, S_DONE
    } state_e;

    state_e        state;
    plan_t         req_plan, plan_q;
    logic [6:0]    addr_q;
    logic          qbit_q;
    logic [7:0]    cmd_q, lo_q, hi_q;
    logic [CW-1:0] cnt_q, wlen_q, rlen_q, widx_q, ridx_q, rxc_q;
    logic          err_q;
    logic          req_bad, last_w, last_r;
    logic [CW-1:0] wlen_d, rlen_d, blk_idx_w;
    logic [7:0]    wsel;
    logic          buf_we;

    smb_txn_decode u_dec (.kind(txn_type), .plan(req_plan));

    smb_rx_buf #(.DEPTH(MAX_BLK)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .widx (ridx_q[AW-1:0]),
        .wdata(prim_rx),
        .ridx (rbuf_idx),
        .rdata(rbuf_data)
    );

    // request validation and phase lengths, evaluated on the go cycle
    always_comb begin
        req_bad = req_plan.bad ||
                  (req_plan.needs_len && (wr_count == '0 || wr_count > CW'(MAX_BLK)));
        unique case (req_plan.wm)
            WM_BYTE:    wlen_d = CW'(1);
            WM_WORD:    wlen_d = CW'(2);
            WM_BLK_CNT: wlen_d = wr_count + CW'(1);
            WM_BLK_RAW: wlen_d = wr_count;
            default:    wlen_d = '0;
        endcase
        unique case (req_plan.rm)
            RM_BYTE: rlen_d = CW'(1);
            RM_WORD: rlen_d = CW'(2);
            RM_RAW:  rlen_d = wr_count;
            default: rlen_d = '0;
        endcase
    end

    assign last_w = (widx_q == wlen_q - CW'(1));
    assign last_r = (ridx_q == rlen_q - CW'(1));

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            plan_q <= '{quick: 1'b0, bad: 1'b0, needs_len: 1'b0, wm: WM_NONE, rm: RM_NONE};
            addr_q <= '0;
            qbit_q <= 1'b0;
            cmd_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            cnt_q  <= '0;
            wlen_q <= '0;
            rlen_q <= '0;
            widx_q <= '0;
            ridx_q <= '0;
            rxc_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (go) begin
                    plan_q <= req_plan;
                    addr_q <= dev_addr;
                    qbit_q <= quick_bit;
                    cmd_q  <= cmd_byte;
                    lo_q   <= wr_lo;
                    hi_q   <= wr_hi;
                    cnt_q  <= wr_count;
                    wlen_q <= wlen_d;
                    rlen_q <= rlen_d;
                    widx_q <= '0;
                    ridx_q <= '0;
                    rxc_q  <= '0;
                    err_q  <= req_bad;
                    state  <= req_bad ? S_DONE : S_START;
                end
                S_START: if (prim_done) state <= S_ADDR_W;
                S_ADDR_W: if (prim_done) begin
                    if (!prim_ack) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else if (plan_q.quick) state <= S_STOP;
                    else                       state <= S_CMD;
                end
                S_CMD: if (prim_done) begin
                    if (!prim_ack) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else if (wlen_q != '0)        state <= S_WDAT;
                    else if (plan_q.rm != RM_NONE)    state <= S_RSTART;
                    else                              state <= S_STOP;
                end
                S_WDAT: if (prim_done) begin
                    if (!prim_ack) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else if (last_w) begin
                        state <= (plan_q.rm != RM_NONE) ? S_RSTART : S_STOP;
                    end else begin
                        widx_q <= widx_q + CW'(1);
                    end
                end
                S_RSTART: if (prim_done) state <= S_ADDR_R;
                S_ADDR_R: if (prim_done) begin
                    if (!prim_ack) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else begin
                        state <= (plan_q.rm == RM_CNT) ? S_RCNT : S_RDAT;
                    end
                end
                S_RCNT: if (prim_done) begin
                    if (prim_rx == 8'd0 || 32'(prim_rx) > MAX_BLK) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else begin
                        rlen_q <= CW'(prim_rx);
                        state  <= S_RDAT;
                    end
                end
                S_RDAT: if (prim_done) begin
                    rxc_q <= ridx_q + CW'(1);
                    if (last_r) state  <= S_STOP;
                    else        ridx_q <= ridx_q + CW'(1);
                end
                S_STOP: if (prim_done) state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // write-byte selection for the data phase
    always_comb begin
        blk_idx_w = (plan_q.wm == WM_BLK_CNT) ? widx_q - CW'(1) : widx_q;
        unique case (plan_q.wm)
            WM_WORD:    wsel = (widx_q == '0) ? lo_q : hi_q;
            WM_BLK_CNT: wsel = (widx_q == '0) ? 8'(cnt_q) : blk_wr_byte;
            WM_BLK_RAW: wsel = blk_wr_byte;
            default:    wsel = lo_q;
        endcase
    end

    assign blk_wr_idx = blk_idx_w[AW-1:0];

    // outputs
    always_comb begin
        prim_valid = 1'b1;
        prim_op    = OP_NONE;
        prim_byte  = 8'h00;
        buf_we     = 1'b0;
        done       = 1'b0;
        unique case (state)
            S_IDLE:   prim_valid = 1'b0;
            S_START:  prim_op = OP_START;
            S_ADDR_W: begin
                prim_op   = OP_WRITE;
                prim_byte = {addr_q, plan_q.quick ? qbit_q : 1'b0};
            end
            S_CMD:    begin prim_op = OP_WRITE; prim_byte = cmd_q; end
            S_WDAT:   begin prim_op = OP_WRITE; prim_byte = wsel; end
            S_RSTART: prim_op = OP_RSTART;
            S_ADDR_R: begin prim_op = OP_WRITE; prim_byte = {addr_q, 1'b1}; end
            S_RCNT:   prim_op = OP_RD_ACK;
            S_RDAT:   begin
                prim_op = last_r ? OP_RD_NACK : OP_RD_ACK;
                buf_we  = prim_done;
            end
            S_STOP:   prim_op = OP_STOP;
            S_DONE:   begin prim_valid = 1'b0; done = 1'b1; end
            default:  prim_valid = 1'b0;
        endcase
    end

    assign rx_count = rxc_q;
    assign error    = err_q;

endmodule

// File: rtl/smb_txn_seq_chk.sv
module smb_txn_seq_chk #(
    parameter int MAX_BLK = 32,
    localparam int CW = $clog2(MAX_BLK + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prim_valid,
    input logic [2:0]    prim_op,
    input logic [7:0]    prim_byte,
    input logic          prim_done,
    input logic          prim_ack,
    input logic [CW-1:0] rx_count,
    input logic          done,
    input logic          error
);
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_stop_then_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> $past(prim_valid && prim_op == 3'd6 && prim_done));

    p_hold_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_valid && !prim_done) |=> (prim_valid && $stable(prim_op) && $stable(prim_byte)));

    p_nack_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_valid && prim_op == 3'd3 && prim_done && !prim_ack) |=> (prim_valid && prim_op == 3'd6));

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_count) <= MAX_BLK);

    p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !prim_valid);
endmodule

bind smb_txn_seq smb_txn_seq_chk #(.MAX_BLK(MAX_BLK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prim_valid(prim_valid),
    .prim_op   (prim_op),
    .prim_byte (prim_byte),
    .prim_done (prim_done),
    .prim_ack  (prim_ack),
    .rx_count  (rx_count),
    .done      (done),
    .error     (error)
);

// File: tb/sim_smb_txn_seq.sv
module sim_smb_txn_seq;
    localparam int MAXB = 32;
    localparam int CW   = $clog2(MAXB + 2);
    localparam int AW   = $clog2(MAXB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [3:0]    txn_type = '0;
    logic [6:0]    dev_addr = '0;
    logic          quick_bit = 1'b0;
    logic [7:0]    cmd_byte = '0, wr_lo = '0, wr_hi = '0;
    logic [CW-1:0] wr_count = '0;
    logic [AW-1:0] blk_wr_idx;
    logic [7:0]    blk_wr_byte;
    logic          prim_valid;
    logic [2:0]    prim_op;
    logic [7:0]    prim_byte;
    logic          prim_done = 1'b0, prim_ack = 1'b0;
    logic [7:0]    prim_rx = '0;
    logic [AW-1:0] rbuf_idx = '0;
    logic [7:0]    rbuf_data;
    logic [CW-1:0] rx_count;
    logic          done, error;

    always #10 clk = ~clk;

    assign blk_wr_byte = 8'hC0 ^ 8'(blk_wr_idx);

    smb_txn_seq #(.MAX_BLK(MAXB)) u0 (.*);

    int vecs = 0, fails = 0;

    // engine / target model state
    int       nack_at = -1;
    int       slave_cnt = 0;
    bit       counted = 0;
    int       wnum = 0, rnum = 0, tr_n = 0;
    int       tr_op [128];
    logic [7:0] tr_b [128];
    longint   stop_t = 0;

    // expected trace
    int       ex_n = 0;
    int       ex_op [128];
    logic [7:0] ex_b [128];
    bit       ex_abort, ex_err;
    int       ex_w, ex_rxc;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_val(input int k);
        return 8'(8'h30 + k * 7);
    endfunction

    // bit-engine model with varying latency
    initial begin
        forever begin
            @(negedge clk);
            if (prim_done) begin
                prim_done = 1'b0;
            end else if (prim_valid) begin
                int op, lat;
                logic [7:0] b;
                op = int'(prim_op);
                b  = prim_byte;
                if (tr_n < 128) begin tr_op[tr_n] = op; tr_b[tr_n] = b; end
                tr_n++;
                lat = 1 + (tr_n % 3);
                if (op == 1) begin wnum = 0; rnum = 0; end
                if (op == 3) begin prim_ack = (wnum != nack_at); wnum++; end
                if (op == 4 || op == 5) begin
                    prim_rx = (counted && rnum == 0) ? 8'(slave_cnt) : rd_val(rnum);
                    rnum++;
                end
                repeat (lat) @(negedge clk);
                chk("R13", "request held", int'(prim_valid && prim_op == 3'(op) && prim_byte == b), 1);
                prim_done = 1'b1;
                if (op == 6) stop_t = $time;
            end
        end
    end

    task automatic ep(input int op, input logic [7:0] b);
        if (!ex_abort) begin ex_op[ex_n] = op; ex_b[ex_n] = b; ex_n++; end
    endtask

    task automatic ew(input logic [7:0] b);
        if (!ex_abort) begin
            ep(3, b);
            if (ex_w == nack_at) ex_abort = 1;
            ex_w++;
        end
    endtask

    task automatic build(input int t, input int cnt, input logic [6:0] a, input logic q,
                         input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
        int n;
        bit bad;
        ex_n = 0; ex_abort = 0; ex_w = 0; ex_rxc = 0;
        bad = (t > 10) || ((t >= 7) && (cnt == 0 || cnt > MAXB)) || (t == 8 && 0);
        if (bad) begin ex_err = 1; return; end
        ep(1, 0);
        ew({a, (t == 0) ? q : 1'b0});
        if (t != 0) begin
            ew(c);
            if (t == 2) ew(lo);
            if (t == 4 || t == 5) begin ew(lo); ew(hi); end
            if (t == 7 || t == 8) begin
                ew(8'(cnt));
                for (int i = 0; i < cnt; i++) ew(8'hC0 ^ 8'(i));
            end
            if (t == 10) for (int i = 0; i < cnt; i++) ew(8'hC0 ^ 8'(i));
            if (t == 1 || t == 3 || t == 5 || t == 6 || t == 8 || t == 9) begin
                ep(2, 0);
                ew({a, 1'b1});
                n = (t == 1) ? 1 : (t == 9) ? cnt : 2;
                if (t == 6 || t == 8) begin
                    ep(4, 0);
                    if (!ex_abort && (slave_cnt == 0 || slave_cnt > MAXB)) ex_abort = 1;
                    n = slave_cnt;
                end
                if (!ex_abort) begin
                    for (int j = 0; j < n; j++) ep((j == n - 1) ? 5 : 4, 0);
                    ex_rxc = n;
                end
            end
        end
        ex_err = ex_abort;
        ex_abort = 0;
        ep(6, 0);
    endtask

    function automatic string req_of(input int t);
        case (t)
            0: return "R1";
            1, 2: return "R2";
            3, 4: return "R3";
            5, 8: return "R7";
            6: return "R5";
            7: return "R6";
            9, 10: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input int t, input int cnt, input int nk, input int sc, input logic q);
        bit got = 0;
        string rq;
        logic [6:0] a = 7'h50 + 7'(t);
        logic [7:0] c = 8'h10 + 8'(t);
        nack_at = nk; slave_cnt = sc; counted = (t == 6 || t == 8);
        @(negedge clk);
        txn_type = 4'(t); dev_addr = a; quick_bit = q; cmd_byte = c;
        wr_lo = 8'hA5; wr_hi = 8'h5A; wr_count = CW'(cnt);
        tr_n = 0;
        go = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            go = 1'b0;
            if (done) begin got = 1; break; end
        end
        if (!got) begin
            chk("R12", "watchdog done", 0, 1);
            rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
            return;
        end
        build(t, cnt, a, q, c, 8'hA5, 8'h5A);
        rq = (nk >= 0) ? "R9" : req_of(t);
        if (t == 6 || t == 8) if (sc == 0 || sc > MAXB) rq = "R5";
        chk(rq, "trace length", tr_n, ex_n);
        for (int i = 0; i < ex_n && i < tr_n; i++) begin
            chk((ex_op[i] == 4 || ex_op[i] == 5) ? "R4" : rq, "prim op", tr_op[i], ex_op[i]);
            if (ex_op[i] == 3) chk(rq, "prim byte", int'(tr_b[i]), int'(ex_b[i]));
        end
        chk((ex_n == 0) ? "R10" : rq, "error", int'(error), int'(ex_err));
        chk("R11", "rx_count", int'(rx_count), ex_rxc);
        if (ex_n != 0) chk("R12", "done after stop", int'($time - stop_t), 20);
        for (int j = 0; j < ex_rxc; j++) begin
            rbuf_idx = AW'(j);
            #1;
            chk((t == 3 || t == 5) ? "R3" : "R11", "buffer",
                int'(rbuf_data), int'(rd_val(counted ? j + 1 : j)));
        end
        @(negedge clk);
        chk("R12", "done width", int'(done), 0);
        repeat (2) @(negedge clk);
        chk("R12", "error hold", int'(error), int'(ex_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset done", int'(done), 0);
        chk("R13", "reset valid", int'(prim_valid), 0);
        chk("R12", "reset error", int'(error), 0);
        chk("R11", "reset rx_count", int'(rx_count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 quick, both bit values
        run(0, 0, -1, 0, 1'b0);
        run(0, 0, -1, 0, 1'b1);
        for (int t = 1; t <= 11; t++) begin
            int cl [6] = '{1, 2, 5, 32, 0, 33};
            int sl [5] = '{1, 4, 32, 0, 33};
            int nc = (t >= 7 && t <= 10) ? 6 : 1;
            int ns = (t == 6 || t == 8) ? 5 : 1;
            for (int ci = 0; ci < nc; ci++)
                for (int si = 0; si < ns; si++)
                    run(t, (nc == 1) ? 3 : cl[ci], -1, sl[si], 1'b0);
        end
        for (int t = 12; t <= 15; t++) run(t, 3, -1, 0, 1'b0);
        // R9 NACK at address, command, first and last write
        for (int t = 0; t <= 10; t++) begin
            run(t, 3, 0, 2, 1'b0);
            if (t != 0) run(t, 3, 1, 2, 1'b0);
            if (t == 2 || t == 4 || t == 5 || t == 7 || t == 8 || t == 10) begin
                run(t, 3, 2, 2, 1'b0);
                run(t, 3, (t == 7 || t == 8) ? 5 : (t == 10) ? 4 : (t == 2) ? 2 : 3, 2, 1'b0);
            end
            if (t == 1 || t == 3 || t == 6 || t == 9) run(t, 3, 2, 2, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule